// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two 16-bit buses, A and B, through two independent 8-bit lanes. Each lane can forward data in either direction. It can forward the live value of the opposite bus, or the value held in a per-direction storage register. Each direction of each lane has its own capture strobe, source select and drive enable. Setting the controls of both lanes to the same values gives plain 16-bit operation.

Bidirectional pins are not used inside the core. Each bus appears as a resolved input vector (`a_in`, `b_in`), an output value vector (`a_out`, `b_out`) and a per-lane drive flag (`a_drv`, `b_drv`). The pad ring, or the bench, merges these into the physical bus. A capture strobe is sampled by the core clock, and a low-to-high change of the strobe loads the register.

When a lane drives both buses from their live paths, each output would reinforce its own input. The core does not build this as a combinational loop. It models it with per-bus keeper registers, which freeze while the lane is in that mode. Each bus then keeps the value it had before every other driver let go.

Top module: `dual_lane_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers and both keepers of every lane to zero; afterwards a lane set to forward stored data drives 8'h00 in both directions.
- R2: The A-to-B register of lane n (lane 0 = bits 7:0, lane 1 = bits 15:8) loads that lane's `a_in` bits on a clock edge where `cap_ab[n]` is 1 and was 0 at the previous edge; the B-to-A register loads `b_in` under `cap_ba[n]` the same way; a strobe held at 1 loads only once.
- R3: Register loading takes place for every setting of `src_ab`, `src_ba`, `en_ab` and `en_ba_n`, including isolation.
- R4: `b_drv[n]` follows `en_ab[n]` (active high) and `a_drv[n]` is the inverse of `en_ba_n[n]` (active low).
- R5: With the select at 0 a driven output carries the opposite bus's live lane bits in the same cycle with no register in the path; with the select at 1 it carries that direction's storage register.
- R6: An output lane whose drive flag is 0 presents 8'h00.
- R7: The controls of one lane change neither output values nor drive flags of the other lane.
- R8: When a lane drives both buses with both selects at 0 (hold), `b_out` shows the A value and `a_out` the B value sampled at the last clock edge before hold began, and changes on `a_in` or `b_in` during hold leave the outputs unchanged.
- R9: With both directions enabled and both selects at 1, the stored A value goes to B and the stored B value goes to A at the same time.
- R10: While a lane drives B from its A-to-B register, a rising `cap_ba` loads the driven value seen on `b_in` into the B-to-A register, so one value ends up in both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples strobes and loads registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Resolved value of bus A |
| b_in | input | 16 | Resolved value of bus B |
| cap_ab | input | 2 | Per-lane capture strobe of the A-to-B register |
| cap_ba | input | 2 | Per-lane capture strobe of the B-to-A register |
| src_ab | input | 2 | Per-lane B output source: 0 live A, 1 stored |
| src_ba | input | 2 | Per-lane A output source: 0 live B, 1 stored |
| en_ab | input | 2 | Per-lane drive enable of bus B, active high |
| en_ba_n | input | 2 | Per-lane drive enable of bus A, active low |
| a_out | output | 16 | Value the block drives onto bus A |
| a_drv | output | 2 | Per-lane flag: block drives bus A |
| b_out | output | 16 | Value the block drives onto bus B |
| b_drv | output | 2 | Per-lane flag: block drives bus B |

## Verification
The hold state is the hardest case to reach. The keepers must first hold a known value, so the stimulus puts a lane into live A-to-B transfer and sets the B bus to the value being driven. It waits one edge and only then enables the A direction. After that it moves both input buses to unrelated values for several cycles and expects the frozen values on both outputs. Register loads under isolation and under every other enable setting are seen only later. A final cycle switches the lane to stored output, which brings the loaded values out to the ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Where one output lane takes its value from.
    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2,
        SRC_KEPT   = 2'd3
    } path_src_e;

    // Raw per-lane control bundle as seen at the ports.
    typedef struct packed {
        logic cap_ab;
        logic cap_ba;
        logic src_ab;
        logic src_ba;
        logic en_ab;
        logic en_ba_n;
    } lane_ctrl_t;

    // Decoded routing for one lane.
    typedef struct packed {
        path_src_e to_b;
        path_src_e to_a;
        logic      hold;
    } lane_route_t;

    function automatic lane_route_t route_lane(input lane_ctrl_t c);
        lane_route_t r;
        logic        drive_b;
        logic        drive_a;
        drive_b = c.en_ab;
        drive_a = ~c.en_ba_n;
        r.hold  = drive_b & drive_a & ~c.src_ab & ~c.src_ba;
        if (!drive_b)      r.to_b = SRC_OFF;
        else if (r.hold)   r.to_b = SRC_KEPT;
        else if (c.src_ab) r.to_b = SRC_STORED;
        else               r.to_b = SRC_LIVE;
        if (!drive_a)      r.to_a = SRC_OFF;
        else if (r.hold)   r.to_a = SRC_KEPT;
        else if (c.src_ba) r.to_a = SRC_STORED;
        else               r.to_a = SRC_LIVE;
        return r;
    endfunction

endpackage

// File: rtl/xcvr_edge_reg.sv
module xcvr_edge_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic strobe_q;
    logic fire;

    // Rising strobe seen between two clock samples.
    assign fire = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        strobe_q <= strobe;
        if (rst) begin
            q <= '0;
        end else if (fire) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         freeze,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!freeze) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  path_src_e    src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic [W-1:0] kept,
    output logic [W-1:0] y,
    output logic         drv
);

    always_comb begin
        case (src)
            SRC_LIVE:   y = live;
            SRC_STORED: y = stored;
            SRC_KEPT:   y = kept;
            default:    y = '0;
        endcase
    end

    assign drv = (src != SRC_OFF);

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] ab_q,
    output logic [W-1:0] ba_q,
    output logic         hold
);

    lane_route_t  route;
    logic [W-1:0] a_keep;
    logic [W-1:0] b_keep;

    assign route = route_lane(ctrl);
    assign hold  = route.hold;

    xcvr_edge_reg #(.W(W)) u_reg_ab (
        .clk(clk), .rst(rst), .strobe(ctrl.cap_ab), .d(a_in), .q(ab_q)
    );

    xcvr_edge_reg #(.W(W)) u_reg_ba (
        .clk(clk), .rst(rst), .strobe(ctrl.cap_ba), .d(b_in), .q(ba_q)
    );

    xcvr_keeper #(.W(W)) u_keep_a (
        .clk(clk), .rst(rst), .freeze(route.hold), .d(a_in), .q(a_keep)
    );

    xcvr_keeper #(.W(W)) u_keep_b (
        .clk(clk), .rst(rst), .freeze(route.hold), .d(b_in), .q(b_keep)
    );

    xcvr_path_mux #(.W(W)) u_mux_b (
        .src(route.to_b), .live(a_in), .stored(ab_q), .kept(a_keep),
        .y(b_out), .drv(b_drv)
    );

    xcvr_path_mux #(.W(W)) u_mux_a (
        .src(route.to_a), .live(b_in), .stored(ba_q), .kept(b_keep),
        .y(a_out), .drv(a_drv)
    );

endmodule

// File: rtl/dual_lane_xcvr.sv
module dual_lane_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] src_ab,
    input  logic [LANES-1:0] src_ba,
    input  logic [LANES-1:0] en_ab,
    input  logic [LANES-1:0] en_ba_n,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_drv,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_drv
);

    logic [BUS_W-1:0] ab_store;
    logic [BUS_W-1:0] ba_store;
    logic [LANES-1:0] lane_hold;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        lane_ctrl_t ctrl;

        assign ctrl = '{cap_ab:  cap_ab[g],
                        cap_ba:  cap_ba[g],
                        src_ab:  src_ab[g],
                        src_ba:  src_ba[g],
                        en_ab:   en_ab[g],
                        en_ba_n: en_ba_n[g]};

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl),
            .a_in  (a_in[LO +: LANE_W]),
            .b_in  (b_in[LO +: LANE_W]),
            .a_out (a_out[LO +: LANE_W]),
            .a_drv (a_drv[g]),
            .b_out (b_out[LO +: LANE_W]),
            .b_drv (b_drv[g]),
            .ab_q  (ab_store[LO +: LANE_W]),
            .ba_q  (ba_store[LO +: LANE_W]),
            .hold  (lane_hold[g])
        );
    end

endmodule

// File: rtl/dual_lane_xcvr_chk.sv
module dual_lane_xcvr_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] b_in,
    input logic [LANES-1:0] cap_ab,
    input logic [LANES-1:0] cap_ba,
    input logic [LANES-1:0] src_ab,
    input logic [LANES-1:0] src_ba,
    input logic [LANES-1:0] en_ab,
    input logic [LANES-1:0] en_ba_n,
    input logic [BUS_W-1:0] a_out,
    input logic [LANES-1:0] a_drv,
    input logic [BUS_W-1:0] b_out,
    input logic [LANES-1:0] b_drv,
    input logic [BUS_W-1:0] ab_store,
    input logic [BUS_W-1:0] ba_store,
    input logic [LANES-1:0] lane_hold
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        localparam int LO = g * LANE_W;

        AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
            (cap_ab[g] && !$past(cap_ab[g])) |=> (ab_store[LO +: LANE_W] == $past(a_in[LO +: LANE_W]))); // R2

        AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
            (cap_ba[g] && !$past(cap_ba[g])) |=> (ba_store[LO +: LANE_W] == $past(b_in[LO +: LANE_W]))); // R2

        AST_AB_KEEP: assert property (@(posedge clk) disable iff (rst)
            !(cap_ab[g] && !$past(cap_ab[g])) |=> $stable(ab_store[LO +: LANE_W])); // R3

        AST_BA_KEEP: assert property (@(posedge clk) disable iff (rst)
            !(cap_ba[g] && !$past(cap_ba[g])) |=> $stable(ba_store[LO +: LANE_W])); // R3

        AST_DRIVE_POLARITY: assert property (@(posedge clk) disable iff (rst)
            (b_drv[g] == en_ab[g]) && (a_drv[g] == !en_ba_n[g])); // R4

        AST_STORED_TO_B: assert property (@(posedge clk) disable iff (rst)
            (en_ab[g] && src_ab[g]) |-> (b_out[LO +: LANE_W] == ab_store[LO +: LANE_W])); // R5

        AST_QUIET_B: assert property (@(posedge clk) disable iff (rst)
            !b_drv[g] |-> (b_out[LO +: LANE_W] == '0)); // R6

        AST_QUIET_A: assert property (@(posedge clk) disable iff (rst)
            !a_drv[g] |-> (a_out[LO +: LANE_W] == '0)); // R6

        AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
            (lane_hold[g] && $past(lane_hold[g])) |->
                ($stable(b_out[LO +: LANE_W]) && $stable(a_out[LO +: LANE_W]))); // R8

        AST_EXCHANGE: assert property (@(posedge clk) disable iff (rst)
            (en_ab[g] && !en_ba_n[g] && src_ab[g] && src_ba[g]) |->
                ((b_out[LO +: LANE_W] == ab_store[LO +: LANE_W]) &&
                 (a_out[LO +: LANE_W] == ba_store[LO +: LANE_W]))); // R9
    end

endmodule

bind dual_lane_xcvr dual_lane_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (.*);

// File: tb/dual_lane_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_lane_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  cap_ab = '0, cap_ba = '0, src_ab = '0, src_ba = '0;
    logic [1:0]  en_ab = '0, en_ba_n = 2'b11;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_drv, b_drv;

    // Staged stimulus, applied 4 ns after a rising edge.
    logic        s_rst = 1'b1;
    logic [15:0] s_a = '0, s_b = '0;
    logic [1:0]  s_cab = '0, s_cba = '0, s_sab = '0, s_sba = '0;
    logic [1:0]  s_eab = '0, s_eban = 2'b11;

    // Reference state.
    logic [7:0]  m_ab [2];
    logic [7:0]  m_ba [2];
    logic [7:0]  m_ak [2];
    logic [7:0]  m_bk [2];
    logic [1:0]  m_pab = '0, m_pba = '0;

    typedef struct {
        string       tag;
        logic [15:0] ao;
        logic [15:0] bo;
        logic [1:0]  ad;
        logic [1:0]  bd;
    } item_t;
    item_t sb_q[$];

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    dual_lane_xcvr dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .src_ab(src_ab), .src_ba(src_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    // Driver: apply staged inputs, push expected outputs, advance model.
    task automatic cycle(input string tag);
        item_t it;
        @(posedge clk);
        #4;
        rst = s_rst; a_in = s_a; b_in = s_b;
        cap_ab = s_cab; cap_ba = s_cba; src_ab = s_sab; src_ba = s_sba;
        en_ab = s_eab; en_ba_n = s_eban;
        it.tag = tag; it.ao = '0; it.bo = '0;
        it.ad = ~en_ba_n; it.bd = en_ab;
        for (int l = 0; l < 2; l++) begin
            logic hold;
            hold = en_ab[l] & ~en_ba_n[l] & ~src_ab[l] & ~src_ba[l];
            if (en_ab[l])
                it.bo[l*8 +: 8] = hold ? m_ak[l] : (src_ab[l] ? m_ab[l] : a_in[l*8 +: 8]);
            if (!en_ba_n[l])
                it.ao[l*8 +: 8] = hold ? m_bk[l] : (src_ba[l] ? m_ba[l] : b_in[l*8 +: 8]);
            if (rst) begin
                m_ab[l] = '0; m_ba[l] = '0; m_ak[l] = '0; m_bk[l] = '0;
            end else begin
                if (cap_ab[l] && !m_pab[l]) m_ab[l] = a_in[l*8 +: 8];
                if (cap_ba[l] && !m_pba[l]) m_ba[l] = b_in[l*8 +: 8];
                if (!hold) begin
                    m_ak[l] = a_in[l*8 +: 8];
                    m_bk[l] = b_in[l*8 +: 8];
                end
            end
        end
        m_pab = cap_ab; m_pba = cap_ba;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (a_out !== it.ao || b_out !== it.bo || a_drv !== it.ad || b_drv !== it.bd) begin
                errors++;
                $display("FAIL %s act a_out=%h a_drv=%b b_out=%h b_drv=%b exp a_out=%h a_drv=%b b_out=%h b_drv=%b",
                         it.tag, a_out, a_drv, b_out, b_drv, it.ao, it.ad, it.bo, it.bd);
            end
        end
    end

    task automatic isolate_all();
        s_cab = '0; s_cba = '0; s_sab = '0; s_sba = '0; s_eab = '0; s_eban = 2'b11;
    endtask

    initial begin
        for (int l = 0; l < 2; l++) begin
            m_ab[l] = '0; m_ba[l] = '0; m_ak[l] = '0; m_bk[l] = '0;
        end
        // R1: reset, then stored view of both lanes in both directions
        s_a = 16'hFFFF; s_b = 16'hFFFF;
        cycle("R1"); cycle("R1");
        s_rst = 0; s_eab = 2'b11; s_eban = 2'b00; s_sab = 2'b11; s_sba = 2'b11;
        cycle("R1");

        // R2: edge-triggered load, held strobe loads once
        for (int l = 0; l < 2; l++) begin
            isolate_all();
            s_a = 16'h0000; s_b = 16'h0000;
            s_a[l*8 +: 8] = 8'hA5 ^ 8'(l); s_b[l*8 +: 8] = 8'h3C + 8'(l);
            s_cab[l] = 1; s_cba[l] = 1;
            cycle("R2");
            s_a[l*8 +: 8] = 8'h11; s_b[l*8 +: 8] = 8'h22;
            cycle("R2");
            s_cab = '0; s_cba = '0;
            s_eab[l] = 1; s_eban[l] = 0; s_sab[l] = 1; s_sba[l] = 1;
            cycle("R2"); cycle("R2");
        end

        // R3/R4: every control setting on each lane, loads mixed in
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < 16; c++) begin
                isolate_all();
                s_eab[l] = c[0]; s_eban[l] = c[1]; s_sab[l] = c[2]; s_sba[l] = c[3];
                s_a = 16'(c * 16'h1357 + l); s_b = 16'(c * 16'h2468 + 16'h0F0F);
                s_cab[l] = 1; s_cba[l] = 1;
                cycle("R3");
                s_cab = '0; s_cba = '0;
                s_a = ~s_a; s_b = s_b ^ 16'h5AA5;
                cycle("R4");
                s_eab[l] = 1; s_eban[l] = 0; s_sab[l] = 1; s_sba[l] = 1;
                cycle("R3");
            end
        end

        // R5: live paths follow inputs in the same cycle
        isolate_all();
        s_eab = 2'b11; s_sab = 2'b00;
        for (int k = 0; k < 3; k++) begin
            s_a = 16'(16'h1111 * (k + 3)); s_b = 16'hDEAD;
            cycle("R5");
        end
        isolate_all();
        s_eban = 2'b00; s_sba = 2'b00;
        for (int k = 0; k < 3; k++) begin
            s_b = 16'(16'h0F1E * (k + 1)); s_a = 16'hBEEF;
            cycle("R5");
        end

        // R6: isolation with busy buses
        isolate_all();
        for (int k = 0; k < 3; k++) begin
            s_a = 16'(16'h7A3C + k); s_b = 16'(16'hC3A7 - k);
            cycle("R6");
        end

        // R7: lane 1 fixed live A-to-B while lane 0 controls move
        isolate_all();
        s_a = 16'h9A5C; s_b = 16'h1234;
        s_eab[1] = 1;
        for (int c = 0; c < 16; c++) begin
            s_eab[0] = c[0]; s_eban[0] = c[1]; s_sab[0] = c[2]; s_sba[0] = c[3];
            cycle("R7");
        end

        // R8: enter hold from live A-to-B, then disturb the buses
        for (int l = 0; l < 2; l++) begin
            isolate_all();
            s_a = 16'h0000; s_b = 16'h0000;
            s_a[l*8 +: 8] = 8'h6B + 8'(l); s_b[l*8 +: 8] = 8'h6B + 8'(l);
            s_eab[l] = 1;
            cycle("R8");
            s_eban[l] = 0;
            cycle("R8");
            s_a = 16'hF00F; s_b = 16'h0FF0;
            cycle("R8"); cycle("R8");
            s_a = 16'h1E2D;
            cycle("R8");
        end

        // R9: simultaneous exchange of distinct stored values
        isolate_all();
        s_a = 16'hC1A2; s_b = 16'h3B4D; s_cab = 2'b11; s_cba = 2'b11;
        cycle("R9");
        s_cab = '0; s_cba = '0; s_a = 16'h0; s_b = 16'h0;
        s_eab = 2'b11; s_eban = 2'b00; s_sab = 2'b11; s_sba = 2'b11;
        cycle("R9"); cycle("R9");

        // R10: one value into both registers through the driven B bus
        for (int l = 0; l < 2; l++) begin
            isolate_all();
            s_a = 16'h0000; s_b = 16'h0000;
            s_a[l*8 +: 8] = 8'h5E ^ 8'(l);
            s_cab[l] = 1;
            cycle("R10");
            s_cab = '0; s_a = 16'hFFFF;
            s_eab[l] = 1; s_sab[l] = 1;
            s_b[l*8 +: 8] = 8'h5E ^ 8'(l);
            s_cba[l] = 1;
            cycle("R10");
            s_cba = '0; s_eab = '0; s_b = 16'h0000;
            s_eban[l] = 0; s_sba[l] = 1;
            cycle("R10");
        end

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog all-requirements act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule